// File: doc/BRIEF.md
# Virtual Circuit Label-Swapping Forwarder

This block is the ingress forwarding stage of one input port of a connection-oriented packet switch. Packets arrive as a stream of data beats with start and end markers under a valid/ready handshake. The first beat carries the incoming virtual circuit identifier (VCI) in its low bits. The block uses that VCI as an index into its own per-port connection table. On a hit, it replaces the VCI field with the outgoing VCI for the next link. Every beat of the packet then leaves tagged with the output port and the priority class held in that entry.

The control side fills the table while connections are being set up, one entry per write: valid flag, output port, outgoing VCI and priority. On the packet side, forwarding starts as soon as the header has been looked up. The rest of the packet does not have to be present by then. Beats that arrive during the fixed two-cycle lookup wait in a small input buffer, so order is preserved. A packet whose entry is not valid is discarded whole and counted. Back-pressure on the output stalls the input through the same buffer.

Top module: `vc_label_fwd`

## Requirements
- R1: After reset, every table entry is invalid, `out_valid_o` is low, `in_ready_o` is high and `drop_cnt_o` is zero.
- R2: A control write with `cfg_we_i` high stores valid flag, output port, outgoing VCI and priority at index `cfg_vci_i`. Any packet whose header beat is accepted after the write cycle uses the new contents.
- R3: In the first beat of a forwarded packet, bits [VCI_W-1:0] (bits 7:0 by default) are replaced by the outgoing VCI of the entry. Bits above them and all later beats pass through unchanged.
- R4: Every beat of a forwarded packet carries the entry's output port on `out_port_o` and its priority on `out_prio_o`.
- R5: A packet whose entry is invalid produces no output beat at all, and `drop_cnt_o` rises by exactly one for it.
- R6: A packet already past its lookup keeps that lookup's port, priority and outgoing VCI, even when its entry is rewritten while the packet is still passing through.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the output beat and its tags are held unchanged. No beat is lost or duplicated. `in_ready_o` goes low only while the input buffer is full.
- R8: Beats are emitted in arrival order. This includes beats that arrive while the header is being looked up.
- R9: A beat that arrives with `in_sop_i` low when no packet is open is discarded without output and without counting a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_vci_i | input | VCI_W | Incoming VCI index being written |
| cfg_valid_i | input | 1 | Valid flag for the entry |
| cfg_port_i | input | PORT_W | Output port for the entry |
| cfg_out_vci_i | input | VCI_W | Outgoing VCI for the entry |
| cfg_prio_i | input | PRIO_W | Priority class for the entry |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high |
| in_data_i | input | DATA_W | Input beat data; VCI in low bits of first beat |
| in_sop_i | input | 1 | First beat of packet |
| in_eop_i | input | 1 | Last beat of packet |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | DATA_W | Output beat data, header rewritten |
| out_sop_o | output | 1 | First beat of packet |
| out_eop_o | output | 1 | Last beat of packet |
| out_port_o | output | PORT_W | Output port tag |
| out_prio_o | output | PRIO_W | Priority tag |
| drop_cnt_o | output | CNT_W | Count of packets dropped for invalid entries |

## Verification
The hardest case to reach from the ports is a table rewrite that lands while a packet that has already been looked up is still inside the block. The stimulus forces the output ready low, so a long packet stays parked in the buffer after its lookup. It then rewrites that packet's entry with a new port and outgoing VCI, and only afterwards releases the output. The scoreboard holds the old values for that packet and the new values for a follow-up packet on the same VCI. Random output stalls over back-to-back packets, dropped packets and a stray beat with no start marker cover ordering, drop counting and discard.

// File: rtl/vcl_pkg.sv
package vcl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RES,
    ST_FWD,
    ST_DROP
  } fwd_state_e;
endpackage

// File: rtl/vcl_fifo.sv
module vcl_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = AW'(DEPTH) == '0 ? {1'b1, {AW{1'b0}}} : {1'b0, AW'(DEPTH)};

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> !(cnt_q > FULL_CNT));
endmodule

// File: rtl/vcl_table.sv
module vcl_table #(
  parameter int VCI_W  = 8,
  parameter int PORT_W = 3,
  parameter int PRIO_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [VCI_W-1:0]  wr_addr_i,
  input  logic              wr_vld_i,
  input  logic [PORT_W-1:0] wr_port_i,
  input  logic [VCI_W-1:0]  wr_vci_i,
  input  logic [PRIO_W-1:0] wr_prio_i,
  input  logic              rd_en_i,
  input  logic [VCI_W-1:0]  rd_addr_i,
  output logic              hit_o,
  output logic [PORT_W-1:0] port_o,
  output logic [VCI_W-1:0]  vci_o,
  output logic [PRIO_W-1:0] prio_o
);
  localparam int DEPTH = 1 << VCI_W;
  localparam int EW    = PORT_W + VCI_W + PRIO_W;

  logic [EW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [VCI_W-1:0] addr_q;
  logic             pend_q;
  logic [EW-1:0]    ent_q;
  logic             hit_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= {wr_port_i, wr_vci_i, wr_prio_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (wr_en_i) vld_q[wr_addr_i] <= wr_vld_i;
  end

  // stage 1 captures the index, stage 2 captures the entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      pend_q <= 1'b0;
      hit_q  <= 1'b0;
      ent_q  <= '0;
    end else begin
      pend_q <= rd_en_i;
      if (rd_en_i) addr_q <= rd_addr_i;
      if (pend_q) begin
        hit_q <= vld_q[addr_q];
        ent_q <= mem_q[addr_q];
      end
    end
  end

  assign hit_o  = hit_q;
  assign port_o = ent_q[EW-1 -: PORT_W];
  assign vci_o  = ent_q[PRIO_W +: VCI_W];
  assign prio_o = ent_q[PRIO_W-1:0];

  // R2
  tbl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_addr_i)] == $past(wr_vld_i));
endmodule

// File: rtl/vc_label_fwd.sv
module vc_label_fwd #(
  parameter int DATA_W     = 32,
  parameter int VCI_W      = 8,
  parameter int PORT_W     = 3,
  parameter int PRIO_W     = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [VCI_W-1:0]  cfg_vci_i,
  input  logic              cfg_valid_i,
  input  logic [PORT_W-1:0] cfg_port_i,
  input  logic [VCI_W-1:0]  cfg_out_vci_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [PORT_W-1:0] out_port_o,
  output logic [PRIO_W-1:0] out_prio_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  import vcl_pkg::*;

  localparam int BEAT_W = DATA_W + 2;

  fwd_state_e        state_q, state_d;
  logic              fifo_full, fifo_empty, fifo_pop;
  logic [BEAT_W-1:0] hd_beat;
  logic [DATA_W-1:0] hd_data;
  logic              hd_sop, hd_eop;
  logic              rd_en;
  logic              tbl_hit;
  logic [PORT_W-1:0] tbl_port;
  logic [VCI_W-1:0]  tbl_vci;
  logic [PRIO_W-1:0] tbl_prio;
  logic [CNT_W-1:0]  drop_q;

  assign in_ready_o = !fifo_full;

  vcl_fifo #(.W(BEAT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_valid_i && in_ready_o),
    .data_i  ({in_eop_i, in_sop_i, in_data_i}),
    .full_o  (fifo_full),
    .pop_i   (fifo_pop),
    .data_o  (hd_beat),
    .empty_o (fifo_empty)
  );

  assign hd_data = hd_beat[DATA_W-1:0];
  assign hd_sop  = hd_beat[DATA_W];
  assign hd_eop  = hd_beat[DATA_W+1];

  vcl_table #(.VCI_W(VCI_W), .PORT_W(PORT_W), .PRIO_W(PRIO_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_addr_i (cfg_vci_i),
    .wr_vld_i  (cfg_valid_i),
    .wr_port_i (cfg_port_i),
    .wr_vci_i  (cfg_out_vci_i),
    .wr_prio_i (cfg_prio_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (hd_data[VCI_W-1:0]),
    .hit_o     (tbl_hit),
    .port_o    (tbl_port),
    .vci_o     (tbl_vci),
    .prio_o    (tbl_prio)
  );

  always_comb begin
    state_d     = state_q;
    rd_en       = 1'b0;
    fifo_pop    = 1'b0;
    out_valid_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!fifo_empty) begin
          if (hd_sop) begin
            rd_en   = 1'b1;
            state_d = ST_LOOK;
          end else begin
            fifo_pop = 1'b1;  // stray beat outside a packet
          end
        end
      end
      ST_LOOK: state_d = ST_RES;
      ST_RES:  state_d = tbl_hit ? ST_FWD : ST_DROP;
      ST_FWD: begin
        out_valid_o = !fifo_empty;
        fifo_pop    = out_valid_o && out_ready_i;
        if (fifo_pop && hd_eop) state_d = ST_IDLE;
      end
      ST_DROP: begin
        fifo_pop = !fifo_empty;
        if (fifo_pop && hd_eop) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      drop_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RES && !tbl_hit) drop_q <= drop_q + 1'b1;
    end
  end

  assign out_data_o = hd_sop ? {hd_data[DATA_W-1:VCI_W], tbl_vci} : hd_data;
  assign out_sop_o  = hd_sop;
  assign out_eop_o  = hd_eop;
  assign out_port_o = tbl_port;
  assign out_prio_o = tbl_prio;
  assign drop_cnt_o = drop_q;

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_port_o) && $stable(out_eop_o));

  // R5
  out_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> tbl_hit);

  // R5
  drop_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RES && !tbl_hit) |=> drop_cnt_o == $past(drop_cnt_o) + 1'b1);

  // R6
  tag_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FWD && $past(state_q == ST_FWD)) |-> $stable(out_port_o)
      && $stable(out_prio_o));
endmodule

// File: tb/tb_vc_label_fwd.sv
module tb_vc_label_fwd;
  localparam int DATA_W = 32;
  localparam int VCI_W  = 8;
  localparam int PORT_W = 3;
  localparam int PRIO_W = 2;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic [DATA_W-1:0] d;
    logic              s;
    logic              e;
    logic [PORT_W-1:0] p;
    logic [PRIO_W-1:0] q;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              cfg_we = 1'b0;
  logic [VCI_W-1:0]  cfg_vci = '0;
  logic              cfg_valid = 1'b0;
  logic [PORT_W-1:0] cfg_port = '0;
  logic [VCI_W-1:0]  cfg_ovci = '0;
  logic [PRIO_W-1:0] cfg_prio = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_sop = 1'b0;
  logic              in_eop = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [DATA_W-1:0] out_data;
  logic              out_sop, out_eop;
  logic [PORT_W-1:0] out_port;
  logic [PRIO_W-1:0] out_prio;
  logic [CNT_W-1:0]  drop_cnt;

  vc_label_fwd dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_vci_i(cfg_vci), .cfg_valid_i(cfg_valid),
    .cfg_port_i(cfg_port), .cfg_out_vci_i(cfg_ovci), .cfg_prio_i(cfg_prio),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sop_i(in_sop), .in_eop_i(in_eop),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sop_o(out_sop), .out_eop_o(out_eop), .out_port_o(out_port),
    .out_prio_o(out_prio), .drop_cnt_o(drop_cnt)
  );

  beat_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit hold_low = 1'b0;
  bit rand_rdy = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic              m_vld  [256];
  logic [PORT_W-1:0] m_port [256];
  logic [VCI_W-1:0]  m_ovci [256];
  logic [PRIO_W-1:0] m_prio [256];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // output ready pattern
  initial forever begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = hold_low ? 1'b0 : (rand_rdy ? lfsr[0] : 1'b1);
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected output beat", longint'(out_data), 0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(out_data == e.d, "R3", "data", longint'(out_data), longint'(e.d));
        chk({out_sop, out_eop} == {e.s, e.e}, "R8", "sop/eop order",
            longint'({out_sop, out_eop}), longint'({e.s, e.e}));
        chk({out_port, out_prio} == {e.p, e.q}, "R4", "port/prio tag",
            longint'({out_port, out_prio}), longint'({e.p, e.q}));
      end
    end
  end

  task automatic cfg_write(int vci, bit vld, int port, int ovci, int prio);
    cfg_we = 1'b1; cfg_vci = VCI_W'(vci); cfg_valid = vld;
    cfg_port = PORT_W'(port); cfg_ovci = VCI_W'(ovci); cfg_prio = PRIO_W'(prio);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    m_vld[vci] = vld; m_port[vci] = PORT_W'(port);
    m_ovci[vci] = VCI_W'(ovci); m_prio[vci] = PRIO_W'(prio);
  endtask

  task automatic drive_beat(logic [DATA_W-1:0] d, bit s, bit e);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(int vci, int len, logic [23:0] hi);
    for (int i = 0; i < len; i++) begin
      if (m_vld[vci]) begin
        beat_t b;
        b.d = (i == 0) ? {hi, m_ovci[vci]} : {hi, 8'(i)};
        b.s = (i == 0);
        b.e = (i == len - 1);
        b.p = m_port[vci];
        b.q = m_prio[vci];
        exp_q.push_back(b);
      end
    end
    for (int i = 0; i < len; i++)
      drive_beat((i == 0) ? {hi, 8'(vci)} : {hi, 8'(i)}, i == 0, i == len - 1);
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(posedge clk);
      n++;
    end
    repeat (12) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_vld[i] = 1'b0; m_port[i] = '0; m_ovci[i] = '0; m_prio[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
    chk(drop_cnt == '0, "R1", "drop count after reset", longint'(drop_cnt), 0);
    @(posedge clk);
    #1;

    // R1 R5: unprogrammed entry drops the packet
    send_pkt(9, 4, 24'h111111);
    drain();
    chk(drop_cnt == 16'd1, "R5", "drop count after invalid entry", longint'(drop_cnt), 1);

    // R2 R3 R4: programmed entries
    cfg_write(9, 1'b1, 5, 8'h3C, 2);
    cfg_write(200, 1'b1, 7, 8'hA5, 3);
    cfg_write(0, 1'b1, 1, 8'hFF, 0);
    repeat (2) @(posedge clk);
    #1;
    send_pkt(9, 1, 24'h222222);
    send_pkt(200, 5, 24'h333333);
    send_pkt(0, 3, 24'h444444);
    drain();

    // R9: stray beat without start marker
    drive_beat({24'h555555, 8'd9}, 1'b0, 1'b1);
    send_pkt(9, 2, 24'h666666);
    drain();
    chk(drop_cnt == 16'd1, "R9", "stray beat not counted", longint'(drop_cnt), 1);

    // R7 R8: back-to-back packets under random output stalls
    rand_rdy = 1'b1;
    for (int k = 0; k < 12; k++)
      send_pkt((k % 3 == 0) ? 9 : ((k % 3 == 1) ? 200 : 0), 1 + (k % 6), 24'(32'h700000 + k));
    drain();
    rand_rdy = 1'b0;

    // R6: rewrite entry while packet is parked after its lookup
    hold_low = 1'b1;
    fork
      send_pkt(200, 8, 24'h888888);
      begin
        repeat (10) @(posedge clk);
        #1;
        cfg_write(200, 1'b1, 2, 8'h5A, 1);
        repeat (2) @(posedge clk);
        hold_low = 1'b0;
      end
    join
    drain();
    send_pkt(200, 3, 24'h999999);  // R2: new contents apply to next packet
    drain();

    // R5: invalidate entry, packet dropped mid-stream between good ones
    cfg_write(0, 1'b0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #1;
    rand_rdy = 1'b1;
    send_pkt(9, 3, 24'hAAAAAA);
    send_pkt(0, 5, 24'hBBBBBB);
    send_pkt(9, 2, 24'hCCCCCC);
    drain();
    rand_rdy = 1'b0;
    chk(drop_cnt == 16'd2, "R5", "drop count after invalidation", longint'(drop_cnt), 2);

    // R7: nothing lost
    chk(exp_q.size() == 0, "R7", "beats still expected", longint'(exp_q.size()), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule